// File: doc/BRIEF.md
# JTAG Instruction and Identification Register Unit

This unit is the test access port controller of a configuration memory device. A sixteen-state TAP controller advances on the rising edge of the test clock according to the mode-select input. It holds an eight-bit instruction register and three data registers of its own: a one-bit bypass stage, a 32-bit identification code and a 32-bit user code. In Shift-DR it also routes the serial chain through an external boundary-scan block. Test data out is retimed on the falling test-clock edge and is enabled only while a shift is in progress.

The active instruction chooses the data register and drives the mode flags towards the rest of the device: boundary chain select with its capture, shift and update strobes, external-test drive, clamp and all-outputs-high-impedance. When the configuration-request instruction is active and the controller enters Run-Test/Idle, the unit pulls an open-drain configuration line low for a fixed number of test clocks. The host can use this to restart configuration of the attached FPGA without removing power. The instruction capture pattern reports the device's in-system-programming state and read-security flag to the host.

Top module: `jtag_unit_top`

## Requirements
- R1: From any state, five consecutive test clocks with `tms` high bring the controller to Test-Logic-Reset. That state makes the identification instruction (0xFE) active, so a data scan that follows shifts out the identification code.
- R2: In Capture-IR the instruction shift register loads the pattern bits[7:5]=000, bit4=`isp_active`, bit3=`secure_set`, bit2=0, bits[1:0]=01. It is shifted out LSB first on `tdo`.
- R3: The active instruction changes only at the end of Update-IR, or on reset. Shifting, pausing and exiting in the IR path leave the mode outputs unchanged.
- R4: With the identification instruction (0xFE) active, a data scan shifts out the 32-bit code {version[31:28], family[27:20], product[19:12], maker[11:1], 1}, LSB first. The default is 0x05026093.
- R5: With the user-code instruction (0xFD) active, a data scan shifts out `ucode_value` when `ucode_valid` is 1, and 0xFFFFFFFF when it is 0.
- R6: Opcodes 0xFF (bypass), 0xFA (clamp), 0xFC (high-Z), 0xEE (configure) and every unlisted opcode select a one-bit bypass stage. That stage captures 0, so `tdo` carries 0 first and then `tdi` delayed by one clock.
- R7: When the configure instruction (0xEE) is active and the controller enters Run-Test/Idle, `cfg_pull_low` goes to 1 one test clock later and stays there for CF_CYCLES (default 4) clocks. It never goes to 1 under any other instruction.
- R8: `highz_on` is 1 exactly while 0xFC is active, and `clamp_on` is 1 exactly while 0xFA is active.
- R9: Opcodes 0x00 (external test) and 0x01 (sample/preload) set `bsr_sel` and route `bsr_so` to `tdo` during Shift-DR. `extest_on` is 1 only for 0x00.
- R10: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR.
- R11: A low level on `trst_n` puts the controller in Test-Logic-Reset at once. It clears `tdo_en` and `cfg_pull_low` and makes 0xFE the active instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| isp_active | input | 1 | Device is in in-system-programming mode |
| secure_set | input | 1 | Read-security flag is set |
| ucode_valid | input | 1 | User code has been programmed |
| ucode_value | input | 32 | Programmed user code |
| bsr_so | input | 1 | Serial out of the boundary-scan chain |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for `tdo` |
| cfg_pull_low | output | 1 | 1 pulls the open-drain configuration line low |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift enable |
| bsr_update | output | 1 | Boundary chain update strobe |
| extest_on | output | 1 | Boundary cells drive the pins |
| clamp_on | output | 1 | Outputs held at their boundary values |
| highz_on | output | 1 | All device outputs in high impedance |

## Verification
A TAP controller in the wrong state shows first at `tdo_en`: it is raised or dropped in the wrong clock, half a test clock after the bad transition. A wrongly held instruction shows at once on the mode flags, or within one data scan as the wrong number of bits or a wrong leading bit on `tdo`. A fault in the capture paths only shows during the next scan, as a wrong bit at a known position. A faulty configuration timer shows as a pulse that starts in the wrong clock or has the wrong length, counted in test clocks from the entry to Run-Test/Idle.

// File: rtl/jtag_unit_pkg.sv
package jtag_unit_pkg;

    localparam int IR_W = 8;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
    localparam logic [IR_W-1:0] OP_CONFIG = 8'hEE;
    localparam logic [IR_W-1:0] OP_CLAMP  = 8'hFA;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 8'hFC;
    localparam logic [IR_W-1:0] OP_USER   = 8'hFD;
    localparam logic [IR_W-1:0] OP_IDENT  = 8'hFE;
    localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;

    typedef enum logic [2:0] {
        K_BYPASS, K_SAMPLE, K_EXTEST, K_CLAMP, K_HIGHZ, K_IDENT, K_USER, K_CONFIG
    } instr_kind_t;

    typedef enum logic [1:0] { DR_BYP, DR_ID, DR_USER, DR_BSR } dr_pick_t;

    function automatic instr_kind_t decode_op(input logic [IR_W-1:0] op);
        instr_kind_t k;
        case (op)
            OP_EXTEST: k = K_EXTEST;
            OP_SAMPLE: k = K_SAMPLE;
            OP_CONFIG: k = K_CONFIG;
            OP_CLAMP:  k = K_CLAMP;
            OP_HIGHZ:  k = K_HIGHZ;
            OP_USER:   k = K_USER;
            OP_IDENT:  k = K_IDENT;
            default:   k = K_BYPASS;
        endcase
        return k;
    endfunction

    function automatic dr_pick_t pick_dr(input instr_kind_t k);
        dr_pick_t p;
        unique case (k)
            K_IDENT:            p = DR_ID;
            K_USER:             p = DR_USER;
            K_EXTEST, K_SAMPLE: p = DR_BSR;
            default:            p = DR_BYP;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_unit_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state_q
);
    tap_state_t state_d;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_TLR;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
        endcase
    end
endmodule

// File: rtl/jtag_scan_reg.sv
module jtag_scan_reg #(
    parameter int           W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         cap_en,
    input  logic         shf_en,
    input  logic [W-1:0] cap_val,
    input  logic         tdi,
    output logic         so
);
    logic [W-1:0] sr_q;

    generate
        if (W == 1) begin : g_single
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n)     sr_q <= RESET_VAL;
                else if (cap_en) sr_q <= cap_val;
                else if (shf_en) sr_q <= tdi;
            end
        end else begin : g_multi
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n)     sr_q <= RESET_VAL;
                else if (cap_en) sr_q <= cap_val;
                else if (shf_en) sr_q <= {tdi, sr_q[W-1:1]};
            end
        end
    endgenerate

    assign so = sr_q[0];
endmodule

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
    import jtag_unit_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state_q,
    input  logic            tdi,
    input  logic            isp_active,
    input  logic            secure_set,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so
);
    logic [IR_W-1:0] ir_sr_q;
    logic [IR_W-1:0] cap_pat;

    assign cap_pat = {{(IR_W-5){1'b0}}, isp_active, secure_set, 1'b0, 2'b01};

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr_q <= '0;
        end else if (state_q == ST_CAP_IR) begin
            ir_sr_q <= cap_pat;
        end else if (state_q == ST_SHF_IR) begin
            ir_sr_q <= {tdi, ir_sr_q[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                    ir_q <= OP_IDENT;
        else if (state_q == ST_TLR)     ir_q <= OP_IDENT;
        else if (state_q == ST_UPD_IR)  ir_q <= ir_sr_q;
    end

    assign ir_so = ir_sr_q[0];
endmodule

// File: rtl/jtag_dr_unit.sv
module jtag_dr_unit
    import jtag_unit_pkg::*;
#(
    parameter int          DR_W        = 32,
    parameter logic [3:0]  ID_VERSION  = 4'h0,
    parameter logic [7:0]  ID_FAMILY   = 8'h50,
    parameter logic [7:0]  ID_PRODUCT  = 8'h26,
    parameter logic [10:0] ID_MAKER    = 11'h049
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state_q,
    input  dr_pick_t        pick,
    input  logic            tdi,
    input  logic            ucode_valid,
    input  logic [DR_W-1:0] ucode_value,
    input  logic            bsr_so,
    output logic            dr_so
);
    localparam logic [DR_W-1:0] ID_WORD = {ID_VERSION, ID_FAMILY, ID_PRODUCT, ID_MAKER, 1'b1};
    localparam int N_REG = 3;

    logic            cap_st, shf_st;
    logic [N_REG-1:0] reg_so;
    logic [DR_W-1:0] user_cap;

    assign cap_st   = (state_q == ST_CAP_DR);
    assign shf_st   = (state_q == ST_SHF_DR);
    assign user_cap = ucode_valid ? ucode_value : '1;

    generate
        for (genvar g = 0; g < N_REG; g++) begin : g_reg
            if (g == 0) begin : g_byp
                jtag_scan_reg #(.W(1), .RESET_VAL(1'b0)) u_reg (
                    .tck(tck), .trst_n(trst_n),
                    .cap_en(cap_st && pick == DR_BYP),
                    .shf_en(shf_st && pick == DR_BYP),
                    .cap_val(1'b0), .tdi(tdi), .so(reg_so[g]));
            end else if (g == 1) begin : g_id
                jtag_scan_reg #(.W(DR_W), .RESET_VAL(ID_WORD)) u_reg (
                    .tck(tck), .trst_n(trst_n),
                    .cap_en(cap_st && pick == DR_ID),
                    .shf_en(shf_st && pick == DR_ID),
                    .cap_val(ID_WORD), .tdi(tdi), .so(reg_so[g]));
            end else begin : g_user
                jtag_scan_reg #(.W(DR_W), .RESET_VAL('1)) u_reg (
                    .tck(tck), .trst_n(trst_n),
                    .cap_en(cap_st && pick == DR_USER),
                    .shf_en(shf_st && pick == DR_USER),
                    .cap_val(user_cap), .tdi(tdi), .so(reg_so[g]));
            end
        end
    endgenerate

    always_comb begin
        unique case (pick)
            DR_BYP:  dr_so = reg_so[0];
            DR_ID:   dr_so = reg_so[1];
            DR_USER: dr_so = reg_so[2];
            DR_BSR:  dr_so = bsr_so;
        endcase
    end
endmodule

// File: rtl/jtag_cfg_pulse.sv
module jtag_cfg_pulse
    import jtag_unit_pkg::*;
#(
    parameter int CF_CYCLES = 4
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_t state_q,
    input  logic       cfg_active,
    output logic       pull_low
);
    localparam int CNT_W = $clog2(CF_CYCLES + 1);

    logic             was_idle_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start;

    assign start = (state_q == ST_RTI) && !was_idle_q && cfg_active;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            was_idle_q <= 1'b0;
            cnt_q      <= '0;
        end else begin
            was_idle_q <= (state_q == ST_RTI);
            if (start && cnt_q == '0) cnt_q <= CNT_W'(CF_CYCLES);
            else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pull_low = (cnt_q != '0);
endmodule

// File: rtl/jtag_unit_top.sv
module jtag_unit_top
    import jtag_unit_pkg::*;
#(
    parameter int          DR_W       = 32,
    parameter int          CF_CYCLES  = 4,
    parameter logic [3:0]  ID_VERSION = 4'h0,
    parameter logic [7:0]  ID_FAMILY  = 8'h50,
    parameter logic [7:0]  ID_PRODUCT = 8'h26,
    parameter logic [10:0] ID_MAKER   = 11'h049
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    input  logic            isp_active,
    input  logic            secure_set,
    input  logic            ucode_valid,
    input  logic [DR_W-1:0] ucode_value,
    input  logic            bsr_so,
    output logic            tdo,
    output logic            tdo_en,
    output logic            cfg_pull_low,
    output logic            bsr_sel,
    output logic            bsr_capture,
    output logic            bsr_shift,
    output logic            bsr_update,
    output logic            extest_on,
    output logic            clamp_on,
    output logic            highz_on
);
    tap_state_t      state_q;
    logic [IR_W-1:0] ir_q;
    logic            ir_so, dr_so;
    instr_kind_t     kind;
    dr_pick_t        pick;

    jtag_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state_q));

    jtag_ir_unit u_ir (
        .tck(tck), .trst_n(trst_n), .state_q(state_q), .tdi(tdi),
        .isp_active(isp_active), .secure_set(secure_set),
        .ir_q(ir_q), .ir_so(ir_so));

    assign kind = decode_op(ir_q);
    assign pick = pick_dr(kind);

    jtag_dr_unit #(
        .DR_W(DR_W), .ID_VERSION(ID_VERSION), .ID_FAMILY(ID_FAMILY),
        .ID_PRODUCT(ID_PRODUCT), .ID_MAKER(ID_MAKER)
    ) u_dr (
        .tck(tck), .trst_n(trst_n), .state_q(state_q), .pick(pick), .tdi(tdi),
        .ucode_valid(ucode_valid), .ucode_value(ucode_value),
        .bsr_so(bsr_so), .dr_so(dr_so));

    jtag_cfg_pulse #(.CF_CYCLES(CF_CYCLES)) u_cf (
        .tck(tck), .trst_n(trst_n), .state_q(state_q),
        .cfg_active(kind == K_CONFIG), .pull_low(cfg_pull_low));

    // Output retiming on the falling edge of the test clock.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= (state_q == ST_SHF_IR) ? ir_so : dr_so;
            tdo_en <= (state_q == ST_SHF_IR) || (state_q == ST_SHF_DR);
        end
    end

    always_comb begin
        bsr_sel     = (pick == DR_BSR);
        bsr_capture = bsr_sel && (state_q == ST_CAP_DR);
        bsr_shift   = bsr_sel && (state_q == ST_SHF_DR);
        bsr_update  = bsr_sel && (state_q == ST_UPD_DR);
        extest_on   = (kind == K_EXTEST);
        clamp_on    = (kind == K_CLAMP);
        highz_on    = (kind == K_HIGHZ);
    end
endmodule

// File: rtl/jtag_unit_checker.sv
module jtag_unit_checker
    import jtag_unit_pkg::*;
#(
    parameter int CF_CYCLES = 4
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_state_t      state_q,
    input logic [IR_W-1:0] ir_q,
    input logic            tdo_en,
    input logic            cfg_pull_low
);
    logic [2:0]  ones_cnt;
    logic [15:0] low_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ones_cnt <= '0;
            low_run  <= '0;
        end else begin
            if (!tms)               ones_cnt <= '0;
            else if (ones_cnt != 5) ones_cnt <= ones_cnt + 1'b1;
            low_run <= cfg_pull_low ? low_run + 1'b1 : '0;
        end
    end

    assert_tlr_after_ones_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt == 5) |-> (state_q == ST_TLR));

    assert_tlr_selects_ident_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_TLR) |=> (ir_q == OP_IDENT));

    assert_ir_holds_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q != ST_UPD_IR && state_q != ST_TLR) |=> $stable(ir_q));

    assert_tdo_en_window_R10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (state_q == ST_SHF_IR || state_q == ST_SHF_DR));

    assert_cf_width_R7: assert property (@(posedge tck) disable iff (!trst_n)
        low_run <= 16'(CF_CYCLES));

    assert_cf_only_config_R7: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(cfg_pull_low) |-> (ir_q == OP_CONFIG));
endmodule

bind jtag_unit_top jtag_unit_checker #(.CF_CYCLES(CF_CYCLES)) u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state_q),
    .ir_q(ir_q), .tdo_en(tdo_en), .cfg_pull_low(cfg_pull_low));

// File: tb/jtag_unit_top_bench.sv
module jtag_unit_top_bench;
    localparam int TCK_PERIOD = 10;
    localparam logic [31:0] ID_EXP = 32'h05026093;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic isp_active = 1'b0, secure_set = 1'b0, ucode_valid = 1'b0, bsr_so = 1'b0;
    logic [31:0] ucode_value = '0;
    logic tdo, tdo_en, cfg_pull_low, bsr_sel, bsr_capture, bsr_shift, bsr_update;
    logic extest_on, clamp_on, highz_on;

    int n_checks = 0, n_fails = 0;
    logic en_ok;
    bit done = 0;

    jtag_unit_top u_jtag_unit_top (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .isp_active(isp_active), .secure_set(secure_set),
        .ucode_valid(ucode_valid), .ucode_value(ucode_value), .bsr_so(bsr_so),
        .tdo(tdo), .tdo_en(tdo_en), .cfg_pull_low(cfg_pull_low),
        .bsr_sel(bsr_sel), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .extest_on(extest_on), .clamp_on(clamp_on),
        .highz_on(highz_on));

    always #(TCK_PERIOD/2) tck = ~tck;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic goto_idle();
        repeat (5) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // From Run-Test/Idle through an IR scan and back to Run-Test/Idle.
    task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        en_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cap[i] = tdo;
            if (!tdo_en) en_ok = 1'b0;
            step(i == 7, op[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        en_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (!tdo_en) en_ok = 1'b0;
            step(i == n - 1, din[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(tdo_en == 0 && cfg_pull_low == 0 && highz_on == 0, "R11 reset outputs",
            {29'b0, tdo_en, cfg_pull_low, highz_on}, 32'h0);
        trst_n = 1'b1;
        step(0, 0);
        chk(tdo_en == 0, "R10 tdo_en idle", tdo_en, 0);
        scan_dr(32, 32'h0, d);
        chk(d == ID_EXP, "R11 ident after trst", d, ID_EXP);
        chk(en_ok, "R10 tdo_en during shift", en_ok, 1);
    endtask

    task automatic t_ir_capture();
        logic [7:0] c;
        isp_active = 1; secure_set = 0;
        scan_ir(8'hFE, c);
        chk(c == 8'h11, "R2 capture isp", c, 8'h11);
        chk(en_ok, "R10 tdo_en IR shift", en_ok, 1);
        isp_active = 0; secure_set = 1;
        scan_ir(8'hFE, c);
        chk(c == 8'h09, "R2 capture secure", c, 8'h09);
        secure_set = 0;
    endtask

    task automatic t_idcode();
        logic [31:0] d;
        logic [7:0] c;
        scan_ir(8'hFE, c);
        scan_dr(32, 32'hDEADBEEF, d);
        chk(d == ID_EXP, "R4 ident word", d, ID_EXP);
    endtask

    task automatic t_usercode();
        logic [31:0] d;
        logic [7:0] c;
        ucode_valid = 0;
        scan_ir(8'hFD, c);
        scan_dr(32, 32'h0, d);
        chk(d == 32'hFFFFFFFF, "R5 blank user code", d, 32'hFFFFFFFF);
        ucode_valid = 1; ucode_value = 32'h12345678;
        scan_dr(32, 32'h0, d);
        chk(d == 32'h12345678, "R5 programmed user code", d, 32'h12345678);
        ucode_valid = 0;
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        logic [7:0] c;
        logic [7:0] ops [4] = '{8'hFF, 8'h5A, 8'hFA, 8'hFC};
        for (int k = 0; k < 4; k++) begin
            scan_ir(ops[k], c);
            scan_dr(8, 32'hA5, d);
            chk(d == 32'h4A, "R6 bypass one-bit delay", d, 32'h4A);
            chk(bsr_sel == 0, "R6 no boundary select", bsr_sel, 0);
        end
    endtask

    task automatic t_modes();
        logic [7:0] c;
        scan_ir(8'hFA, c);
        chk(clamp_on && !highz_on, "R8 clamp flag", {clamp_on, highz_on}, 2'b10);
        scan_ir(8'hFC, c);
        chk(highz_on && !clamp_on, "R8 highz flag", {clamp_on, highz_on}, 2'b01);
        scan_ir(8'hFE, c);
        chk(!highz_on && !clamp_on, "R8 flags cleared", {clamp_on, highz_on}, 2'b00);
    endtask

    task automatic t_boundary();
        logic [31:0] d;
        logic [7:0] c;
        bsr_so = 1;
        scan_ir(8'h00, c);
        chk(bsr_sel && extest_on, "R9 extest select", {bsr_sel, extest_on}, 2'b11);
        scan_dr(8, 32'h0, d);
        chk(d == 32'hFF, "R9 extest chain on tdo", d, 32'hFF);
        bsr_so = 0;
        scan_ir(8'h01, c);
        chk(bsr_sel && !extest_on, "R9 sample select", {bsr_sel, extest_on}, 2'b10);
        step(1, 0); step(0, 0); step(0, 0);
        chk(bsr_shift == 1, "R9 boundary shift strobe", bsr_shift, 1);
        chk(tdo == 0, "R9 sample chain on tdo", tdo, 0);
        step(1, 0); step(1, 0); step(0, 0);
    endtask

    task automatic t_ir_hold();
        logic [7:0] c;
        scan_ir(8'hFC, c);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 8; i++) step(i == 7, 1'b0);
        chk(highz_on && !extest_on, "R3 hold in exit", {highz_on, extest_on}, 2'b10);
        step(0, 0);
        chk(highz_on && !extest_on, "R3 hold in pause", {highz_on, extest_on}, 2'b10);
        step(1, 0); step(1, 0);
        chk(highz_on && !extest_on, "R3 hold in update", {highz_on, extest_on}, 2'b10);
        step(0, 0);
        chk(!highz_on && extest_on, "R3 new instruction", {highz_on, extest_on}, 2'b01);
    endtask

    task automatic t_config();
        logic [7:0] c;
        logic [31:0] d;
        int lows;
        scan_ir(8'hEE, c);
        chk(cfg_pull_low == 0, "R7 no pull on entry clock", cfg_pull_low, 0);
        step(0, 0);
        chk(cfg_pull_low == 1, "R7 pull one clock after entry", cfg_pull_low, 1);
        lows = 1;
        for (int i = 0; i < 8; i++) begin
            step(0, 0);
            if (cfg_pull_low) lows++;
        end
        chk(lows == 4, "R7 pull width", lows, 4);
        scan_dr(4, 32'hB, d);
        chk(d == 32'h6, "R6 config uses bypass", d, 32'h6);
        repeat (8) step(0, 0);
        goto_idle();
        lows = 0;
        for (int i = 0; i < 8; i++) begin
            step(0, 0);
            if (cfg_pull_low) lows++;
        end
        chk(lows == 0, "R7 no pull without config", lows, 0);
    endtask

    task automatic t_tms_reset();
        logic [7:0] c;
        logic [31:0] d;
        scan_ir(8'hFD, c);
        step(1, 0); step(0, 0); step(0, 0);
        step(0, 1); step(0, 0); step(0, 1);
        repeat (5) step(1, 0);
        chk(tdo_en == 0, "R1 left shift", tdo_en, 0);
        step(0, 0);
        scan_dr(32, 32'h0, d);
        chk(d == ID_EXP, "R1 ident after tms reset", d, ID_EXP);
    endtask

    task automatic t_trst();
        logic [7:0] c;
        logic [31:0] d;
        scan_ir(8'hFC, c);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(0, 1);
        #2 trst_n = 0; #3 trst_n = 1;
        chk(!highz_on && tdo_en == 0, "R11 async reset", {highz_on, tdo_en}, 2'b00);
        @(negedge tck); #1;
        step(0, 0);
        scan_dr(32, 32'h0, d);
        chk(d == ID_EXP, "R11 ident after async reset", d, ID_EXP);
    endtask

    initial begin
        @(negedge tck); #1;
        t_reset();
        t_ir_capture();
        t_idcode();
        t_usercode();
        t_bypass();
        t_modes();
        t_boundary();
        t_ir_hold();
        t_config();
        t_tms_reset();
        t_trst();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(TCK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule